// File: doc/BRIEF.md
# Coprocessor Test Register with Clock and Memory Gating

This block is a byte-wide control register that sits on the bus of an audio coprocessor. Its fields set four things: how often the coprocessor core receives a clock-enable pulse, whether the core's RAM can be read or written, two timer enable controls, and a two-bit timer speed code. The register accepts a write only while the processor's P status flag is clear.

A small address decoder sits beside the register and shows the gating at work. It drives a RAM write strobe and picks the read data. When RAM is turned off, RAM reads return the constant 0x5A and writes are dropped. The boot ROM window at the top of the address space stays readable in that state. Two scratch I/O registers in the I/O page always accept stores. Their stores are mirrored into RAM only while RAM writes are allowed.

Top module: `cop_testreg_gate`

## Requirements
- R1: After reset the control register at address 0x00F0 reads 0x0A. Out of reset, `core_ce` is high every cycle, `tmr_on` is 1, `tmr_off` is 0 and `tmr_speed` is 0.
- R2: A write to 0x00F0 while `p_flag` is 1 leaves the register unchanged. A write with `p_flag` at 0 takes effect at that clock edge.
- R3: Bits 7:6 set the clock-enable rate. In any 100 consecutive cycles after the code is loaded, code 0 gives 100 pulses, code 1 gives 50 and code 3 gives 10.
- R4: Loading code 2 into bits 7:6 drops `core_ce` to 0. It stays 0 even after bits 7:6 are rewritten, until the next reset.
- R5: When bits 7:6 change, the rate divider restarts. The first pulse comes in cycle 1 after the write for code 0, cycle 2 for code 1 and cycle 10 for code 3.
- R6: `tmr_speed` equals bits 5:4 of the register.
- R7: `tmr_on` equals bit 3 and `tmr_off` equals bit 0.
- R8: While bit 2 is 1, reads of RAM addresses return 0x5A and writes to RAM addresses raise no `ram_we`. RAM addresses are those outside the I/O page 0x00F0–0x00FF and outside 0xFFC0–0xFFFF.
- R9: Reads of 0xFFC0–0xFFFF return `rom_rdata` whether bit 2 is 0 or 1. Address 0xFFBF is a RAM address.
- R10: While bit 1 is 0, no write raises `ram_we`. Stores to the scratch registers at 0x00F8 and 0x00F9 still update them, and they read back the stored byte.
- R11: While bit 1 is 1 and bit 2 is 0, writes to RAM addresses, to the ROM window and to 0x00F8/0x00F9 raise `ram_we`, with `ram_wdata` equal to the bus byte. Writes to 0x00F0 raise no `ram_we`. RAM reads return `ram_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_flag | input | 1 | Processor P status flag; blocks register writes when 1 |
| bus_addr | input | 16 | Coprocessor bus address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| core_ce | output | 1 | Clock enable for the coprocessor core |
| tmr_speed | output | 2 | Timer speed code |
| tmr_on | output | 1 | Timers-enabled control |
| tmr_off | output | 1 | Timers-disabled control |
| mem_addr | output | 16 | Address for RAM and ROM |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| rom_rdata | input | 8 | Boot ROM read data |

## Verification
The bench builds the block with its default parameters: a half-rate divider of 2, a slow divider of 10 and two scratch registers. With these values every rate code completes whole periods inside a 100-cycle counting window, so the pulse totals and first-pulse positions come out as exact integers. Two scratch registers are enough to check the mirrored-store path at both 0x00F8 and 0x00F9. The ROM window boundary at 0xFFBF/0xFFC0 is checked with RAM disabled.

// File: rtl/cop_testreg_pkg.sv
package cop_testreg_pkg;

   typedef enum logic [1:0] {
      RATE_FULL = 2'd0,
      RATE_HALF = 2'd1,
      RATE_STOP = 2'd2,
      RATE_SLOW = 2'd3
   } rate_e;

   // Field order is the bit order of the register (MSB first)
   typedef struct packed {
      rate_e      rate;     // 7:6
      logic [1:0] tspd;     // 5:4
      logic       tmr_on;   // 3
      logic       ram_off;  // 2
      logic       ram_wr;   // 1
      logic       tmr_off;  // 0
   } ctl_t;

   localparam logic [7:0] CTL_RESET     = 8'h0A;
   localparam logic [7:0] DISABLED_BYTE = 8'h5A;

endpackage

// File: rtl/cop_ctl_reg.sv
module cop_ctl_reg
   import cop_testreg_pkg::*;
#(
   parameter int              ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h00F0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p_flag,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output ctl_t              ctl_q,
   output logic              rate_restart
);

   logic accept;
   ctl_t wnew;

   assign accept       = bus_wr && !p_flag && (bus_addr == CTL_ADDR);
   assign wnew         = ctl_t'(bus_wdata);
   assign rate_restart = accept && (wnew.rate != ctl_q.rate);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= ctl_t'(CTL_RESET);
      else if (accept) ctl_q <= wnew;
   end

endmodule

// File: rtl/cop_clk_throttle.sv
module cop_clk_throttle
   import cop_testreg_pkg::*;
#(
   parameter int HALF_DIV = 2,
   parameter int SLOW_DIV = 10
) (
   input  logic  clk,
   input  logic  rst_n,
   input  rate_e rate,
   input  logic  restart,
   output logic  ce
);

   localparam int MAX_DIV = (SLOW_DIV > HALF_DIV) ? SLOW_DIV : HALF_DIV;
   localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

   generate
      if (HALF_DIV < 2 || SLOW_DIV < 2) begin : g_bad_div
         $error("cop_clk_throttle: dividers must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;
   logic             halted;

   always_comb begin
      unique case (rate)
         RATE_HALF: last = CNT_W'(HALF_DIV - 1);
         RATE_SLOW: last = CNT_W'(SLOW_DIV - 1);
         default:   last = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (restart)        cnt <= '0;
      else if (cnt == last)    cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   // Once the stop code is seen the core never runs again before reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  halted <= 1'b0;
      else if (rate == RATE_STOP)  halted <= 1'b1;
   end

   assign ce = !halted && (rate != RATE_STOP) && (cnt == last);

endmodule

// File: rtl/cop_mem_gate.sv
module cop_mem_gate
   import cop_testreg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR    = 16'h00F0,
   parameter logic [ADDR_W-1:0] IO_BASE     = 16'h00F0,
   parameter logic [ADDR_W-1:0] SCR_BASE    = 16'h00F8,
   parameter int                NUM_SCRATCH = 2,
   parameter logic [ADDR_W-1:0] ROM_BASE    = 16'hFFC0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  ctl_t              ctl_q,
   input  logic [7:0]        ram_rdata,
   input  logic [7:0]        rom_rdata,
   output logic [7:0]        bus_rdata,
   output logic              ram_we
);

   logic                   in_io, in_rom, is_ctl, scr_any;
   logic [NUM_SCRATCH-1:0] scr_hit;
   logic [7:0]             scr_q [NUM_SCRATCH];

   assign in_io  = (bus_addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]);
   assign in_rom = (bus_addr >= ROM_BASE);
   assign is_ctl = (bus_addr == CTL_ADDR);

   genvar g;
   generate
      for (g = 0; g < NUM_SCRATCH; g++) begin : g_scr
         assign scr_hit[g] = (bus_addr == SCR_BASE + ADDR_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     scr_q[g] <= '0;
            else if (bus_wr && scr_hit[g])  scr_q[g] <= bus_wdata;
         end
      end
   endgenerate

   assign scr_any = |scr_hit;

   always_comb begin
      bus_rdata = '0;
      if (is_ctl) begin
         bus_rdata = ctl_q;
      end else if (scr_any) begin
         for (int i = 0; i < NUM_SCRATCH; i++)
            if (scr_hit[i]) bus_rdata = scr_q[i];
      end else if (in_io) begin
         bus_rdata = '0;
      end else if (in_rom) begin
         bus_rdata = rom_rdata;
      end else if (ctl_q.ram_off) begin
         bus_rdata = DISABLED_BYTE;
      end else begin
         bus_rdata = ram_rdata;
      end
   end

   // RAM lies under the ROM window and behind the scratch registers
   assign ram_we = bus_wr && !ctl_q.ram_off && ctl_q.ram_wr && (!in_io || scr_any);

endmodule

// File: rtl/cop_testreg_gate.sv
module cop_testreg_gate
   import cop_testreg_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR    = 16'h00F0,
   parameter logic [ADDR_W-1:0] IO_BASE     = 16'h00F0,
   parameter logic [ADDR_W-1:0] SCR_BASE    = 16'h00F8,
   parameter int                NUM_SCRATCH = 2,
   parameter logic [ADDR_W-1:0] ROM_BASE    = 16'hFFC0,
   parameter int                HALF_DIV    = 2,
   parameter int                SLOW_DIV    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              p_flag,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              core_ce,
   output logic [1:0]        tmr_speed,
   output logic              tmr_on,
   output logic              tmr_off,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              ram_we,
   output logic [7:0]        ram_wdata,
   input  logic [7:0]        ram_rdata,
   input  logic [7:0]        rom_rdata
);

   localparam logic [ADDR_W-1:0] IO_LAST = IO_BASE | ADDR_W'(15);

   generate
      if (ADDR_W < 8) begin : g_bad_w
         $error("cop_testreg_gate: ADDR_W too small");
      end
      if (NUM_SCRATCH < 1 || NUM_SCRATCH > 8) begin : g_bad_scr
         $error("cop_testreg_gate: NUM_SCRATCH out of range");
      end
      if (SCR_BASE < IO_BASE || SCR_BASE + ADDR_W'(NUM_SCRATCH - 1) > IO_LAST) begin : g_bad_scr_loc
         $error("cop_testreg_gate: scratch registers outside I/O page");
      end
      if (CTL_ADDR < IO_BASE || CTL_ADDR > IO_LAST || ROM_BASE <= IO_LAST) begin : g_bad_map
         $error("cop_testreg_gate: address map inconsistent");
      end
   endgenerate

   ctl_t ctl_q;
   logic rate_restart;

   cop_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .p_flag       (p_flag),
      .bus_addr     (bus_addr),
      .bus_wr       (bus_wr),
      .bus_wdata    (bus_wdata),
      .ctl_q        (ctl_q),
      .rate_restart (rate_restart)
   );

   cop_clk_throttle #(.HALF_DIV(HALF_DIV), .SLOW_DIV(SLOW_DIV)) u_thr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rate    (ctl_q.rate),
      .restart (rate_restart),
      .ce      (core_ce)
   );

   cop_mem_gate #(
      .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .IO_BASE(IO_BASE),
      .SCR_BASE(SCR_BASE), .NUM_SCRATCH(NUM_SCRATCH), .ROM_BASE(ROM_BASE)
   ) u_mem (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .ctl_q     (ctl_q),
      .ram_rdata (ram_rdata),
      .rom_rdata (rom_rdata),
      .bus_rdata (bus_rdata),
      .ram_we    (ram_we)
   );

   assign tmr_speed = ctl_q.tspd;
   assign tmr_on    = ctl_q.tmr_on;
   assign tmr_off   = ctl_q.tmr_off;
   assign mem_addr  = bus_addr;
   assign ram_wdata = bus_wdata;

endmodule

// File: rtl/cop_testreg_chk.sv
module cop_testreg_chk #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 16'h00F0,
   parameter logic [ADDR_W-1:0] IO_BASE  = 16'h00F0,
   parameter logic [ADDR_W-1:0] ROM_BASE = 16'hFFC0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              p_flag,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [7:0]        bus_rdata,
   input logic              core_ce,
   input logic              ram_we,
   input logic [7:0]        rom_rdata,
   input logic [7:0]        ctl_q
);

   logic seen_stop;
   logic ram_region, rom_region;

   assign rom_region = (bus_addr >= ROM_BASE);
   assign ram_region = !rom_region && (bus_addr[ADDR_W-1:4] != IO_BASE[ADDR_W-1:4]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   seen_stop <= 1'b0;
      else if (ctl_q[7:6] == 2'd2)  seen_stop <= 1'b1;
   end

   assert_p_blocks_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && p_flag && bus_addr == CTL_ADDR) |=> (ctl_q == $past(ctl_q)));

   assert_halt_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_stop || ctl_q[7:6] == 2'd2) |-> !core_ce);

   assert_half_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[7:6] == 2'd1 && $past(ctl_q[7:6]) == 2'd1 && $past(core_ce)) |-> !core_ce);

   assert_disabled_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[2] && ram_region) |-> (bus_rdata == 8'h5A));

   assert_no_we_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[2] |-> !ram_we);

   assert_rom_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rom_region |-> (bus_rdata == rom_rdata));

   assert_no_we_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[1] |-> !ram_we);

endmodule

bind cop_testreg_gate cop_testreg_chk #(
   .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .IO_BASE(IO_BASE), .ROM_BASE(ROM_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .p_flag    (p_flag),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_rdata (bus_rdata),
   .core_ce   (core_ce),
   .ram_we    (ram_we),
   .rom_rdata (rom_rdata),
   .ctl_q     (ctl_q)
);

// File: tb/cop_testreg_gate_bench.sv
`timescale 1ns/1ps
module cop_testreg_gate_bench;

   localparam int SEL_RDATA = 0, SEL_WE = 1, SEL_CE = 2, SEL_TSPD = 3,
                  SEL_TON = 4, SEL_TOFF = 5, SEL_WDATA = 6;
   localparam logic [7:0] RAM_VAL = 8'h77;
   localparam logic [7:0] ROM_VAL = 8'hC3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        p_flag = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        core_ce;
   logic [1:0]  tmr_speed;
   logic        tmr_on, tmr_off;
   logic [15:0] mem_addr;
   logic        ram_we;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata = RAM_VAL;
   logic [7:0]  rom_rdata = ROM_VAL;

   int checks = 0;
   int errors = 0;

   typedef struct {
      string tag;
      int    sel;
      int    exp;
   } item_t;
   item_t sb[$];

   always #4 clk = ~clk;

   cop_testreg_gate u_cop_testreg_gate (
      .clk(clk), .rst_n(rst_n), .p_flag(p_flag), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_ce(core_ce), .tmr_speed(tmr_speed), .tmr_on(tmr_on), .tmr_off(tmr_off),
      .mem_addr(mem_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .rom_rdata(rom_rdata)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected items and compares against the ports
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sb.size() > 0) begin
            item_t it;
            int    act;
            it = sb.pop_front();
            case (it.sel)
               SEL_RDATA: act = int'(bus_rdata);
               SEL_WE:    act = int'(ram_we);
               SEL_CE:    act = int'(core_ce);
               SEL_TSPD:  act = int'(tmr_speed);
               SEL_TON:   act = int'(tmr_on);
               SEL_TOFF:  act = int'(tmr_off);
               default:   act = int'(ram_wdata);
            endcase
            check(it.tag, act, it.exp);
         end
      end
   end

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic p);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; p_flag = p;
      @(posedge clk);
      #1;
      bus_wr = 1'b0; p_flag = 1'b0;
   endtask

   task automatic exp_rd(input logic [15:0] a, input int exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      sb.push_back('{tag, SEL_RDATA, exp});
   endtask

   task automatic exp_we(input logic [15:0] a, input logic [7:0] d, input int exp, input string tag);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      sb.push_back('{tag, SEL_WE, exp});
      if (exp != 0) sb.push_back('{tag, SEL_WDATA, int'(d)});
      @(posedge clk);
      #1;
      bus_wr = 1'b0;
   endtask

   task automatic exp_sig(input int sel, input int exp, input string tag);
      @(negedge clk);
      bus_wr = 1'b0;
      sb.push_back('{tag, sel, exp});
   endtask

   task automatic count_ce(input int n, output int pulses, output int first);
      pulses = 0; first = -1;
      for (int i = 1; i <= n; i++) begin
         @(negedge clk);
         #2;
         if (core_ce) begin
            pulses++;
            if (first < 0) first = i;
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int pulses, first;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      exp_rd(16'h00F0, 8'h0A, "R1 reset value");
      exp_sig(SEL_CE,   1, "R1 ce after reset");
      exp_sig(SEL_TON,  1, "R1 tmr_on after reset");
      exp_sig(SEL_TOFF, 0, "R1 tmr_off after reset");
      exp_sig(SEL_TSPD, 0, "R1 tmr_speed after reset");

      // R2 write blocked while P set, accepted when clear
      wr(16'h00F0, 8'h35, 1'b1);
      exp_rd(16'h00F0, 8'h0A, "R2 write ignored with P set");

      // R6 R7 field outputs
      wr(16'h00F0, 8'h39, 1'b0);
      exp_rd(16'h00F0, 8'h39, "R2 write accepted with P clear");
      exp_sig(SEL_TSPD, 3, "R6 speed code 3");
      exp_sig(SEL_TON,  1, "R7 tmr_on bit3=1");
      exp_sig(SEL_TOFF, 1, "R7 tmr_off bit0=1");
      wr(16'h00F0, 8'h26, 1'b0);
      exp_sig(SEL_TSPD, 2, "R6 speed code 2");
      exp_sig(SEL_TON,  0, "R7 tmr_on bit3=0");
      exp_sig(SEL_TOFF, 0, "R7 tmr_off bit0=0");

      // R8 R9 RAM disabled (0x26: bit2=1, bit1=1)
      exp_rd(16'h1234, 8'h5A, "R8 disabled RAM read");
      exp_rd(16'hFFBF, 8'h5A, "R9 0xFFBF is RAM");
      exp_we(16'h1234, 8'hAB, 0, "R8 disabled RAM write dropped");
      exp_rd(16'hFFC0, ROM_VAL, "R9 ROM first byte visible");
      exp_rd(16'hFFFF, ROM_VAL, "R9 ROM last byte visible");

      // R10 RAM enabled, write-protected (0x08)
      wr(16'h00F0, 8'h08, 1'b0);
      exp_rd(16'h0200, RAM_VAL, "R11 read with bit1=0 still reads RAM");
      exp_we(16'h0200, 8'h44, 0, "R10 RAM write blocked");
      exp_we(16'h00F8, 8'h11, 0, "R10 scratch F8 not mirrored");
      exp_rd(16'h00F8, 8'h11, "R10 scratch F8 updated");
      exp_we(16'h00F9, 8'h22, 0, "R10 scratch F9 not mirrored");
      exp_rd(16'h00F9, 8'h22, "R10 scratch F9 updated");

      // R11 fully enabled (0x0A)
      wr(16'h00F0, 8'h0A, 1'b0);
      exp_we(16'h0300, 8'h5C, 1, "R11 RAM write strobed");
      exp_we(16'h00F8, 8'h33, 1, "R11 scratch F8 mirrored");
      exp_rd(16'h00F8, 8'h33, "R11 scratch F8 readback");
      exp_we(16'hFFD0, 8'h66, 1, "R11 write under ROM window");
      exp_we(16'h00F0, 8'h0A, 0, "R11 register write not mirrored");
      exp_rd(16'h0300, RAM_VAL, "R11 RAM read data");
      exp_rd(16'hFFD0, ROM_VAL, "R9 ROM visible with RAM on");

      // R3 R5 clock rates and divider restart
      wr(16'h00F0, 8'h4A, 1'b0);
      count_ce(100, pulses, first);
      check("R3 code1 pulses/100", pulses, 50);
      check("R5 code1 first pulse", first, 2);
      wr(16'h00F0, 8'hCA, 1'b0);
      count_ce(100, pulses, first);
      check("R3 code3 pulses/100", pulses, 10);
      check("R5 code3 first pulse", first, 10);
      count_ce(5, pulses, first);
      wr(16'h00F0, 8'h4A, 1'b0);
      count_ce(4, pulses, first);
      check("R5 restart mid-period code1 first", first, 2);
      wr(16'h00F0, 8'h0A, 1'b0);
      count_ce(100, pulses, first);
      check("R3 code0 pulses/100", pulses, 100);
      check("R5 code0 first pulse", first, 1);

      // R4 permanent halt
      wr(16'h00F0, 8'h8A, 1'b0);
      count_ce(100, pulses, first);
      check("R4 code2 pulses/100", pulses, 0);
      wr(16'h00F0, 8'h0A, 1'b0);
      exp_rd(16'h00F0, 8'h0A, "R4 register rewritten during halt");
      count_ce(20, pulses, first);
      check("R4 halt persists after rewrite", pulses, 0);
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      exp_sig(SEL_CE, 1, "R4 reset ends halt");
      exp_rd(16'h00F0, 8'h0A, "R1 reset value after second reset");

      repeat (2) @(negedge clk);
      #3;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule